// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets an external controller read and write a byte-wide internal register space over a four-wire synchronous serial link: an active-low select, a serial clock, a data input and a data output. Every transfer opens with a 16-bit instruction word. That word sets the direction, the number of data bytes and the first register address. The data bytes follow it. The controller can shift either the most or the least significant bit first. Read data can leave on the shared bidirectional pin or on a separate output pin.

The port runs on the chip's system clock and detects serial clock edges by sampling. It drives a simple register bus: an address, write data, a one-cycle write strobe, and read data that the register file returns combinationally from the address. The block has no analog pin drivers. It provides output-enable signals, and the pad ring builds the tri-state buffers from them.

A transfer of one, two or three bytes may be paused by raising select on any byte boundary. Raising select in the middle of a byte drops the transfer. Streaming mode runs for as many bytes as the controller sends, and the register address steps by one after each byte.

Top module: `serreg_port`

## Requirements
- R1: A transfer starts when `cs_n` is low. The first 16 rising edges of `sclk` shift in the instruction word. With MSB-first order, instruction bit 15 arrives first. With LSB-first order, bit 0 arrives first.
- R2: Instruction layout: bit 15 selects read (1) or write (0). Bits 14:13 hold the length code: 00 = 1 byte, 01 = 2, 10 = 3, 11 = streaming. Bits 12:0 hold the start address.
- R3: Once a 1-, 2- or 3-byte transfer has moved its last byte, further `sclk` edges cause no register access until `cs_n` goes high.
- R4: In a write, each completed data byte gives exactly one single-cycle `reg_we` pulse. During that pulse, `reg_addr` carries the byte's address and `reg_wdata` carries the byte.
- R5: In a non-streaming transfer, `cs_n` high on a byte boundary stalls the port in either phase. The transfer resumes where it stopped when `cs_n` returns low.
- R6: In streaming mode, any number of data bytes may follow. The transfer ends when `cs_n` goes high.
- R7: After each data byte the address steps by one. It decrements in MSB-first order and increments in LSB-first order.
- R8: Data bytes are shifted bit 7 first in MSB-first order and bit 0 first in LSB-first order.
- R9: `cs_n` high in the middle of a byte aborts the transfer with no register write. The next low period starts with a new instruction.
- R10: Read data bits change only after a falling `sclk` edge, so the controller can sample them on the rising edge. Both output enables are low whenever `cs_n` is high and after reset.
- R11: With `cfg_sep_sdo` = 0, `sdio_oe` rises at the first falling edge of a read's data phase. It is never high during the instruction phase, and `sdo_oe` stays low.
- R12: With `cfg_sep_sdo` = 1, read data leaves on `sdo_out` with `sdo_oe` high, and `sdio_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the controller |
| sclk | input | 1 | Serial clock, already synchronized to `clk` |
| sdio_in | input | 1 | Serial data in from the bidirectional pin |
| sdio_out | output | 1 | Serial data out toward the bidirectional pin |
| sdio_oe | output | 1 | Drive enable for the bidirectional pin |
| sdo_out | output | 1 | Serial data out for the separate output pin |
| sdo_oe | output | 1 | Drive enable for the separate output pin |
| cfg_lsb_first | input | 1 | 1 = least significant bit first, address increments |
| cfg_sep_sdo | input | 1 | 1 = read data on the separate output pin |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Register read data, combinational from `reg_addr` |

## Verification
The hardest situations to reach are the ones where `cs_n` rises at a point that only the bit counter inside the port can tell apart. These are a boundary stall in the middle of the instruction, a mid-byte abort, and extra bytes after a completed short transfer. The stimulus reaches them by sending partial instructions, four-bit fragments and surplus bytes from the serial master tasks. A reference queue of expected writes, checked on every clock, then shows that no stray strobe appeared and that the next clean transfer lands at the right address.

// File: rtl/serreg_port.sv
module serreg_port #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo_out,
  output logic              sdo_oe,
  input  logic              cfg_lsb_first,
  input  logic              cfg_sep_sdo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  input  logic [7:0]        reg_rdata
);
  localparam int IW = ADDR_W + 3;
  localparam int CW = $clog2(IW);

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_t;

  phase_t         ph;
  logic           sclk_q, rd, step, drv, dout;
  logic [1:0]     len, nb;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  ish;
  logic [7:0]     dsh;

  wire rise     = ~cs_n & sclk & ~sclk_q;
  wire fall     = ~cs_n & ~sclk & sclk_q;
  wire boundary = (cnt[2:0] == 3'd0);
  wire stream   = (len == 2'b11);
  wire last_b   = ~stream & (nb == len);
  wire [2:0] bsel = cfg_lsb_first ? cnt[2:0] : 3'd7 - cnt[2:0];

  wire [IW-1:0] ish_nx = cfg_lsb_first ? {sdio_in, ish[IW-1:1]} : {ish[IW-2:0], sdio_in};
  wire [7:0]    dsh_nx = cfg_lsb_first ? {sdio_in, dsh[7:1]}    : {dsh[6:0], sdio_in};

  assign sdio_out = dout;
  assign sdo_out  = dout;
  assign sdio_oe  = drv & ~cfg_sep_sdo & ~cs_n;
  assign sdo_oe   = drv &  cfg_sep_sdo & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_INSTR;
      sclk_q <= 1'b0;
      cnt <= '0;
      ish <= '0;
      dsh <= '0;
      rd <= 1'b0;
      len <= 2'b00;
      nb <= 2'b00;
      step <= 1'b0;
      drv <= 1'b0;
      dout <= 1'b0;
      reg_addr <= '0;
      reg_wdata <= '0;
      reg_we <= 1'b0;
    end else begin
      sclk_q <= sclk;
      reg_we <= 1'b0;
      step   <= 1'b0;
      if (step)
        reg_addr <= cfg_lsb_first ? reg_addr + ADDR_W'(1) : reg_addr - ADDR_W'(1);
      if (cs_n) begin
        if (!boundary || ph == PH_DONE || (ph == PH_DATA && stream)) begin
          ph  <= PH_INSTR;
          cnt <= '0;
          nb  <= 2'b00;
          drv <= 1'b0;
        end
      end else if (rise) begin
        case (ph)
          PH_INSTR: begin
            ish <= ish_nx;
            if (cnt == CW'(IW-1)) begin
              ph       <= PH_DATA;
              cnt      <= '0;
              nb       <= 2'b00;
              rd       <= ish_nx[IW-1];
              len      <= ish_nx[IW-2 -: 2];
              reg_addr <= ish_nx[ADDR_W-1:0];
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DATA: begin
            dsh <= dsh_nx;
            if (cnt[2:0] == 3'd7) begin
              cnt  <= '0;
              step <= 1'b1;
              nb   <= nb + 1'b1;
              if (!rd) begin
                reg_we    <= 1'b1;
                reg_wdata <= dsh_nx;
              end
              if (last_b) ph <= PH_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end else if (fall && ph == PH_DATA && rd) begin
        dout <= reg_rdata[bsel];
        drv  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serreg_port_chk.sv
module serreg_port_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          cfg_sep_sdo,
  input logic          sdio_oe,
  input logic          sdo_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr
);
  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> (!sdio_oe && !sdo_oe)); // R10
  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(sdio_oe && sdo_oe)); // R11
  AST_SEP_KEEPS_SDIO_OFF: assert property (@(posedge clk) disable iff (!rst_n) cfg_sep_sdo |-> !sdio_oe); // R12
  AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we); // R4
  AST_WE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> $past(!cs_n)); // R9
  AST_ADDR_HELD_AT_WE: assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> $stable(reg_addr)); // R7
endmodule

bind serreg_port serreg_port_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cfg_sep_sdo(cfg_sep_sdo),
  .sdio_oe(sdio_oe), .sdo_oe(sdo_oe), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/serreg_port_bench.sv
module serreg_port_bench;
  localparam int AW = 13;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
  logic lsb = 1'b0, sep = 1'b0;
  logic sdio_out, sdio_oe, sdo_out, sdo_oe, reg_we;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [0:63];

  int checks = 0, fails = 0, cycles = 0;
  int q_addr[$];
  int q_data[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  serreg_port #(.ADDR_W(AW)) u_serreg_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .cfg_lsb_first(lsb), .cfg_sep_sdo(sep), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 7 + 3) % 256);
  endfunction

  assign reg_rdata = mem[reg_addr[5:0]];

  initial for (int i = 0; i < 64; i++) mem[i] = init_val(i);
  always @(posedge clk) if (reg_we) mem[reg_addr[5:0]] <= reg_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      chk(1'b0, "watchdog expired", cycles, 0);
      summary();
    end
  end

  // cycle-by-cycle reference: every strobe must match the next expected write
  always @(negedge clk) if (rst_n) begin
    if (reg_we) begin
      if (q_addr.size() == 0) chk(1'b0, "R3/R9 unexpected write", int'(reg_addr), -1);
      else begin
        int ea, ed; string t;
        ea = q_addr.pop_front(); ed = q_data.pop_front(); t = q_tag.pop_front();
        chk(int'(reg_addr) == ea, {t, " address"}, int'(reg_addr), ea);
        chk(int'(reg_wdata) == ed, {t, " data"}, int'(reg_wdata), ed);
      end
    end
    if (cs_n) chk(!sdio_oe && !sdo_oe, "R10 enables off while deselected", {sdio_oe, sdo_oe}, 0);
  end

  task automatic expect_wr(input int a, input int d, input string t);
    q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); cs_n = 1'b1; repeat (6) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    @(negedge clk); sdio_in = b;
    repeat (3) @(negedge clk);
    s = sep ? sdo_out : sdio_out;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_instr(input bit rd, input int ln, input int addr, input bit stall);
    logic [15:0] w; logic s;
    w = {rd, 2'(ln), 13'(addr)};
    for (int i = 0; i < 16; i++) begin
      if (stall && i == 8) begin desel(); sel(); end
      bit_io(lsb ? w[i] : w[15 - i], s);
      chk(!sdio_oe && !sdo_oe, "R11 no drive in instruction", {sdio_oe, sdo_oe}, 0);
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) bit_io(lsb ? d[i] : d[7 - i], s);
  endtask

  task automatic recv_byte(output logic [7:0] r);
    logic s;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b0, s);
      if (lsb) r = {s, r[7:1]}; else r = {r[6:0], s};
      if (sep) chk(sdo_oe && !sdio_oe, "R12 separate pin drives", {sdio_oe, sdo_oe}, 1);
      else     chk(sdio_oe && !sdo_oe, "R11 shared pin drives", {sdio_oe, sdo_oe}, 2);
    end
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    chk(!sdio_oe && !sdo_oe && !reg_we, "R10 reset state", {sdio_oe, sdo_oe, reg_we}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R4: single-byte write, MSB first
    expect_wr(16'h0010, 8'hA5, "R1/R2/R4 single write");
    sel(); send_instr(0, 0, 16'h0010, 0); send_byte(8'hA5); desel();

    // R5 R7: three bytes, stalls in instruction and between data bytes, address decrements
    expect_wr(16'h0020, 8'h11, "R5/R7 stalled write b0");
    expect_wr(16'h001F, 8'h22, "R5/R7 stalled write b1");
    expect_wr(16'h001E, 8'h33, "R5/R7 stalled write b2");
    sel(); send_instr(0, 2, 16'h0020, 1);
    send_byte(8'h11); desel(); sel();
    send_byte(8'h22); desel(); sel();
    send_byte(8'h33); desel();

    // R8 R7: LSB first, address increments
    lsb = 1'b1;
    expect_wr(16'h0030, 8'hC1, "R8/R7 lsb write b0");
    expect_wr(16'h0031, 8'h5E, "R8/R7 lsb write b1");
    sel(); send_instr(0, 1, 16'h0030, 0); send_byte(8'hC1); send_byte(8'h5E); desel();
    lsb = 1'b0;

    // R6: streaming five bytes
    for (int k = 0; k < 5; k++) expect_wr(16'h0040 - k, 8'h80 + k, "R6/R7 stream write");
    sel(); send_instr(0, 3, 16'h0040, 0);
    for (int k = 0; k < 5; k++) send_byte(8'(8'h80 + k));
    desel();

    // R9: abort mid-byte, then a clean transfer
    sel(); send_instr(0, 0, 16'h0005, 0);
    begin logic s; for (int i = 0; i < 4; i++) bit_io(1'b1, s); end
    desel();
    expect_wr(16'h0005, 8'h3C, "R9 write after abort");
    sel(); send_instr(0, 0, 16'h0005, 0); send_byte(8'h3C); desel();

    // R3: surplus byte after a completed one-byte transfer
    expect_wr(16'h0006, 8'h77, "R3 only byte");
    sel(); send_instr(0, 0, 16'h0006, 0); send_byte(8'h77); send_byte(8'hFF); desel();

    // R10 R11: two-byte read, shared pin, MSB first
    sel(); send_instr(1, 1, 16'h0008, 0);
    recv_byte(r); chk(r == init_val(8), "R10/R11 read b0", r, init_val(8));
    recv_byte(r); chk(r == init_val(7), "R10/R7 read b1", r, init_val(7));
    desel();

    // R12 R8: one-byte read, separate pin, LSB first
    lsb = 1'b1; sep = 1'b1;
    sel(); send_instr(1, 0, 16'h002A, 0);
    recv_byte(r); chk(r == init_val(42), "R12/R8 read", r, init_val(42));
    desel();
    lsb = 1'b0; sep = 1'b0;

    repeat (10) @(negedge clk);
    chk(q_addr.size() == 0, "R4 all expected writes seen", q_addr.size(), 0);
    summary();
  end
endmodule